// File: doc/BRIEF.md
# Linear Scan Address Walker

This block keeps a two-dimensional data-counter location and moves it through data memory along a straight-line path. A start command gives a signed step vector, a number of steps and a transformation code. The block turns, mirrors or reverses the vector while it accepts the command. It then adds the resulting vector to the location once per accepted output and presents each new location on a valid/ready handshake. Address generation runs without further commands. A one-cycle done pulse follows the last step.

Between patterns the data counter keeps its last value, so each new pattern starts where the previous one ended. A separate moveto input loads an absolute location. Only linear patterns are handled. Memory, window registers, nested patterns and parallel patterns are outside this block.

Top module: `scan_walker`

## Requirements
- R1: During and after reset, pos_x, pos_y, busy, out_valid and done are all zero.
- R2: When the block is idle, move_en loads (move_x, move_y) into the data counter at the next clock edge. A move_en while busy is ignored, and so is a start in the same cycle as move_en.
- R3: With xform code 0 (no transform) and a count of n, the block emits the locations start+k·(dx,dy) for k = 1..n, one per handshake. After each handshake pos_x/pos_y equal the emitted location.
- R4: While out_valid is high and out_ready is low, out_x, out_y and the data counter hold their values.
- R5: In the cycle after the last handshake, busy is low and done is high for exactly one cycle. The data counter then keeps the final location until the next moveto or pattern.
- R6: A count of 0 raises done in the cycle after the start, emits nothing and leaves the data counter unchanged.
- R7: xform code 1 uses (dy, −dx), code 2 uses (−dy, dx) and code 3 uses (−dx, −dy).
- R8: xform code 4 uses (−dx, dy) and code 5 uses (dx, −dy). Codes 0 and 7 leave the vector unchanged.
- R9: xform code 6 (reverse) sets the data counter to start+n·(dx,dy) when the start is accepted. It then steps by (−dx, −dy), so the last emitted location is the original start.
- R10: A start while busy is ignored. The running pattern continues with its own vector and count.
- R11: Coordinates are 8-bit and wrap modulo 256. Step components are 4-bit two's complement and the count is 8-bit unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new pattern (ignored while busy) |
| step_dx | input | 4 | Signed x step component |
| step_dy | input | 4 | Signed y step component |
| step_count | input | 8 | Number of steps |
| xform | input | 3 | Transformation code (see R7, R8, R9) |
| move_en | input | 1 | Load the data counter directly (idle only) |
| move_x | input | 8 | Moveto x coordinate |
| move_y | input | 8 | Moveto y coordinate |
| out_ready | input | 1 | Consumer accepts the presented location |
| out_valid | output | 1 | A location is presented |
| out_x | output | 8 | Presented x coordinate |
| out_y | output | 8 | Presented y coordinate |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | One-cycle pulse after a pattern ends |
| pos_x | output | 8 | Current data-counter x |
| pos_y | output | 8 | Current data-counter y |

## Verification
The case that is hardest to reach from the ports is a command that arrives while a pattern is halfway through. Both start and move_en must be raised, with a different vector and count, during a step of a running pattern, and the bench must then confirm that every later location still follows the original vector. The bench does this from inside its pattern task: at a chosen step it drives the intruding command for one cycle. In another pattern it drops out_ready for two cycles at a chosen step to check the stall hold. The reverse case is reached by starting a reversed pattern and checking the data counter before the first handshake, where it must already sit at the far end point.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int COORD_W = 8;
    localparam int STEP_W  = 4;
    localparam int CNT_W   = 8;
    localparam int VEC_W   = STEP_W + 1;

    typedef logic [COORD_W-1:0]      coord_t;
    typedef logic [CNT_W-1:0]        count_t;
    typedef logic signed [VEC_W-1:0] comp_t;

    typedef enum logic [2:0] {
        XF_NONE    = 3'd0,
        XF_ROTL    = 3'd1,
        XF_ROTR    = 3'd2,
        XF_ROT180  = 3'd3,
        XF_FLIPX   = 3'd4,
        XF_FLIPY   = 3'd5,
        XF_REVERSE = 3'd6,
        XF_SPARE   = 3'd7
    } xform_e;

    typedef struct packed {
        comp_t dx;
        comp_t dy;
    } vec_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } loc_t;

    function automatic vec_t vec_neg(vec_t v);
        vec_t r;
        r.dx = -v.dx;
        r.dy = -v.dy;
        return r;
    endfunction

    function automatic vec_t vec_turn(vec_t v, xform_e f);
        vec_t r;
        r = v;
        case (f)
            XF_ROTL:   begin r.dx = v.dy;  r.dy = -v.dx; end
            XF_ROTR:   begin r.dx = -v.dy; r.dy = v.dx;  end
            XF_ROT180: r = vec_neg(v);
            XF_FLIPX:  r.dx = -v.dx;
            XF_FLIPY:  r.dy = -v.dy;
            default:   r = v;
        endcase
        return r;
    endfunction

    function automatic loc_t loc_step(loc_t p, vec_t v);
        loc_t r;
        r.x = p.x + coord_t'(COORD_W'(v.dx));
        r.y = p.y + coord_t'(COORD_W'(v.dy));
        return r;
    endfunction

    function automatic loc_t loc_far(loc_t p, vec_t v, count_t n);
        loc_t   r;
        coord_t nn;
        nn  = coord_t'(n);
        r.x = p.x + coord_t'(coord_t'(COORD_W'(v.dx)) * nn);
        r.y = p.y + coord_t'(coord_t'(COORD_W'(v.dy)) * nn);
        return r;
    endfunction

endpackage

// File: rtl/scan_vec_xform.sv
module scan_vec_xform
    import scan_pkg::*;
(
    input  vec_t   raw_vec,
    input  xform_e mode,
    output vec_t   base_vec,
    output vec_t   walk_vec,
    output logic   is_rev
);
    always_comb begin
        base_vec = vec_turn(raw_vec, mode);
        is_rev   = (mode == XF_REVERSE);
        walk_vec = is_rev ? vec_neg(base_vec) : base_vec;
    end
endmodule

// File: rtl/scan_step_ctr.sv
module scan_step_ctr
    import scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  count_t load_val,
    input  logic   dec,
    output logic   last
);
    count_t remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && remain_q != '0) begin
            remain_q <= remain_q - count_t'(1);
        end
    end

    assign last = (remain_q == count_t'(1));
endmodule

// File: rtl/scan_pos_reg.sv
module scan_pos_reg
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  loc_t set_loc,
    input  logic jump_en,
    input  loc_t jump_loc,
    input  logic step_en,
    input  loc_t step_loc,
    output loc_t pos
);
    loc_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (set_en) begin
            pos_q <= set_loc;
        end else if (jump_en) begin
            pos_q <= jump_loc;
        end else if (step_en) begin
            pos_q <= step_loc;
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/scan_walker.sv
module scan_walker
    import scan_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [STEP_W-1:0] step_dx,
    input  logic signed [STEP_W-1:0] step_dy,
    input  logic [CNT_W-1:0]         step_count,
    input  logic [2:0]               xform,
    input  logic                     move_en,
    input  logic [COORD_W-1:0]       move_x,
    input  logic [COORD_W-1:0]       move_y,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [COORD_W-1:0]       out_x,
    output logic [COORD_W-1:0]       out_y,
    output logic                     busy,
    output logic                     done,
    output logic [COORD_W-1:0]       pos_x,
    output logic [COORD_W-1:0]       pos_y
);
    vec_t   raw_vec, base_vec, walk_vec, run_vec_q;
    logic   is_rev, busy_q, done_q, last;
    logic   set_en, accept, fire, jump_en;
    loc_t   pos, next_loc, far_loc, set_loc;
    count_t cnt;

    assign raw_vec.dx = VEC_W'(step_dx);
    assign raw_vec.dy = VEC_W'(step_dy);
    assign cnt        = count_t'(step_count);
    assign set_loc    = '{x: move_x, y: move_y};

    scan_vec_xform u_xform (
        .raw_vec  (raw_vec),
        .mode     (xform_e'(xform)),
        .base_vec (base_vec),
        .walk_vec (walk_vec),
        .is_rev   (is_rev)
    );

    assign set_en   = move_en && !busy_q;
    assign accept   = start && !busy_q && !move_en;
    assign fire     = busy_q && out_ready;
    assign far_loc  = loc_far(pos, base_vec, cnt);
    assign jump_en  = accept && is_rev && (cnt != '0);
    assign next_loc = loc_step(pos, run_vec_q);

    scan_step_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cnt),
        .dec      (fire),
        .last     (last)
    );

    scan_pos_reg u_pos (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_loc  (set_loc),
        .jump_en  (jump_en),
        .jump_loc (far_loc),
        .step_en  (fire),
        .step_loc (next_loc),
        .pos      (pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            run_vec_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                run_vec_q <= walk_vec;
                if (cnt == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (fire && last) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign out_valid = busy_q;
    assign out_x     = next_loc.x;
    assign out_y     = next_loc.y;
    assign busy      = busy_q;
    assign done      = done_q;
    assign pos_x     = pos.x;
    assign pos_y     = pos.y;
endmodule

// File: rtl/scan_walker_chk.sv
module scan_walker_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       move_en,
    input logic [7:0] move_x,
    input logic [7:0] move_y,
    input logic       out_ready,
    input logic       out_valid,
    input logic [7:0] out_x,
    input logic [7:0] out_y,
    input logic       busy,
    input logic       done,
    input logic [7:0] pos_x,
    input logic [7:0] pos_y
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)); // R4

    AST_STEP_LANDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> pos_x == $past(out_x) && pos_y == $past(out_y)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !start && !move_en |=> $stable(pos_x) && $stable(pos_y)); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !out_valid); // R5

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start) && !$past(move_en)); // R10

    AST_MOVE_LOADS: assert property (@(posedge clk) disable iff (rst)
        !busy && move_en |=> pos_x == $past(move_x) && pos_y == $past(move_y)); // R2
endmodule

bind scan_walker scan_walker_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .move_en   (move_en),
    .move_x    (move_x),
    .move_y    (move_y),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .busy      (busy),
    .done      (done),
    .pos_x     (pos_x),
    .pos_y     (pos_y)
);

// File: tb/scan_walker_tb_top.sv
module scan_walker_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic signed [3:0] step_dx = '0;
    logic signed [3:0] step_dy = '0;
    logic [7:0]        step_count = '0;
    logic [2:0]        xform = '0;
    logic              move_en = 1'b0;
    logic [7:0]        move_x = '0;
    logic [7:0]        move_y = '0;
    logic              out_ready = 1'b1;
    logic              out_valid, busy, done;
    logic [7:0]        out_x, out_y, pos_x, pos_y;

    int n_chk = 0;
    int n_bad = 0;
    int ex = 0;
    int ey = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    scan_walker dut_i (
        .clk(clk), .rst(rst), .start(start), .step_dx(step_dx), .step_dy(step_dy),
        .step_count(step_count), .xform(xform), .move_en(move_en), .move_x(move_x),
        .move_y(move_y), .out_ready(out_ready), .out_valid(out_valid), .out_x(out_x),
        .out_y(out_y), .busy(busy), .done(done), .pos_x(pos_x), .pos_y(pos_y)
    );

    function automatic int wrap(int v);
        return ((v % 256) + 256) % 256;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_move(int x, int y);
        @(negedge clk);
        move_en = 1'b1; move_x = 8'(x); move_y = 8'(y);
        @(negedge clk);
        move_en = 1'b0;
        ex = x; ey = y;
        chk("R2", "moveto x", int'(pos_x), ex);
        chk("R2", "moveto y", int'(pos_y), ey);
    endtask

    // Runs one pattern and checks every emitted location against the bench model.
    task automatic run_pat(string req, int dx, int dy, int n, int xf, int stall_at, int poke_at);
        int vx, vy, x0, y0;
        x0 = ex; y0 = ey;
        case (xf)
            1: begin vx = dy;  vy = -dx; end
            2: begin vx = -dy; vy = dx;  end
            3: begin vx = -dx; vy = -dy; end
            4: begin vx = -dx; vy = dy;  end
            5: begin vx = dx;  vy = -dy; end
            6: begin vx = -dx; vy = -dy; end
            default: begin vx = dx; vy = dy; end
        endcase
        @(negedge clk);
        start = 1'b1; step_dx = 4'(dx); step_dy = 4'(dy);
        step_count = 8'(n); xform = 3'(xf);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk("R6", "done after zero count", int'(done), 1);
            chk("R6", "no output", int'(out_valid), 0);
            chk("R6", "pos x unchanged", int'(pos_x), ex);
            chk("R6", "pos y unchanged", int'(pos_y), ey);
            return;
        end
        if (xf == 6) begin
            ex = wrap(ex + n * dx); ey = wrap(ey + n * dy);
            chk("R9", "jump x", int'(pos_x), ex);
            chk("R9", "jump y", int'(pos_y), ey);
        end
        for (int k = 1; k <= n; k++) begin
            int nx, ny;
            nx = wrap(ex + vx); ny = wrap(ey + vy);
            chk(req, "valid", int'(out_valid), 1);
            chk(req, "out x", int'(out_x), nx);
            chk(req, "out y", int'(out_y), ny);
            if (k == stall_at) begin
                out_ready = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk("R4", "stall out x", int'(out_x), nx);
                chk("R4", "stall out y", int'(out_y), ny);
                chk("R4", "stall pos x", int'(pos_x), ex);
                out_ready = 1'b1;
            end
            if (k == poke_at) begin
                start = 1'b1; move_en = 1'b1; move_x = 8'd77; move_y = 8'd77;
                step_dx = 4'sd0; step_dy = 4'sd3; step_count = 8'd9; xform = 3'd0;
            end
            ex = nx; ey = ny;
            @(negedge clk);
            start = 1'b0; move_en = 1'b0;
            chk(req, "pos x after step", int'(pos_x), ex);
            chk(req, "pos y after step", int'(pos_y), ey);
        end
        chk("R5", "done pulse", int'(done), 1);
        chk("R5", "busy low", int'(busy), 0);
        @(negedge clk);
        chk("R5", "done one cycle", int'(done), 0);
        chk("R5", "pos x held", int'(pos_x), ex);
        chk("R5", "pos y held", int'(pos_y), ey);
        if (xf == 6) begin
            chk("R9", "back at start x", ex, x0);
            chk("R9", "back at start y", ey, y0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pos x reset", int'(pos_x), 0);
        chk("R1", "busy reset", int'(busy), 0);
        chk("R1", "valid reset", int'(out_valid), 0);
        chk("R1", "done reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pos y after reset", int'(pos_y), 0);

        do_move(10, 10);
        run_pat("R3", 1, 0, 1, 0, 0, 0);
        run_pat("R3", -1, 1, 7, 0, 3, 0);
        run_pat("R7", 1, 0, 2, 1, 0, 0);
        run_pat("R7", 2, 1, 3, 2, 0, 0);
        run_pat("R7", 1, 2, 2, 3, 0, 0);
        run_pat("R8", 3, -2, 2, 4, 0, 0);
        run_pat("R8", 3, -2, 2, 5, 0, 0);
        run_pat("R8", 2, 1, 1, 7, 0, 0);
        do_move(30, 20);
        run_pat("R9", -1, 1, 7, 6, 0, 0);
        run_pat("R6", 1, 1, 0, 0, 0, 0);
        run_pat("R6", 2, 2, 0, 6, 0, 0);
        run_pat("R10", 1, 0, 4, 0, 0, 2);
        do_move(254, 1);
        run_pat("R11", 1, -2, 3, 0, 0, 0);
        run_pat("R11", -8, 7, 2, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule